// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a CPU access to an 8-bit internal register file through a single 16-bit window register. One write to the window carries three fields: a 6-bit window address, a read/not-write flag and a data byte. That write starts one access on the internal register bus. The internal bus may answer after any number of cycles. When it answers, the bridge raises a done flag. On a read, it also keeps the byte that came back.

The compact window addresses do not map straight onto the internal register offsets. A fixed translation places each one. Window addresses beyond the map never reach the internal bus. They still complete, so software that polls the done flag never stalls.

Top module: `regwin_bridge`

## Requirements
- R1: The window reads back as {done, 7'b0, data}: bit 15 is the done flag, bits 14:8 read as zero and bits 7:0 hold the data byte. After reset the window reads 0x0000 and no bus request is raised.
- R2: A window write made while idle starts exactly one internal access. Bit 14 of the written value selects the access type (1 = read, 0 = write), bits 13:8 are the window address and bits 7:0 are the write data. Request, offset, direction and write data stay constant until the acknowledge.
- R3: The done flag is cleared by the edge that starts an access. It is set by the edge on which the internal bus acknowledges, and it stays set until the next access starts.
- R4: A read access loads the data byte with the byte returned by the internal bus. A write access leaves the data byte equal to the byte written.
- R5: Window addresses 0x00–0x05, 0x0B–0x0E and 0x10 reach the internal offset of the same value.
- R6: Window address 0x06 reaches offset 0x0A. Window addresses 0x07–0x0A reach offsets 0x06–0x09. Window address 0x0F reaches offset 0x60.
- R7: Window addresses 0x11–0x13 reach offsets 0x12–0x14. Window addresses 0x14–0x1B reach offsets 0x16–0x1D. Offsets 0x11 and 0x15 are never used.
- R8: A window write that arrives while an access is pending is ignored. It does not change the access in flight, its result, the data byte or the number of bus accesses.
- R9: Window addresses 0x1C–0x3F raise no internal request. A read of one returns 0x00 and a write is dropped. Either access sets the done flag on the second edge after the window write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_we_i | input | 1 | Window write strobe |
| win_wdata_i | input | 16 | Window write value |
| win_rdata_o | output | 16 | Window read value |
| ibus_req_o | output | 1 | Internal access request, held until acknowledged |
| ibus_we_o | output | 1 | Internal access is a write |
| ibus_addr_o | output | 8 | Internal register offset |
| ibus_wdata_o | output | 8 | Internal write byte |
| ibus_ack_i | input | 1 | Internal access complete |
| ibus_rdata_i | input | 8 | Internal read byte, valid with acknowledge |

## Verification
The bench checks the timing of each result as follows:
- **Request:** rises on the edge that takes the window write. The bench checks this, and that the done flag has cleared, at the falling edge right after that write.
- **Done flag and read byte (mapped addresses):** appear on the acknowledge edge. The bench polls at falling edges and compares the data byte once done is seen. It also checks the offset and direction the responder recorded against a table of the expected mapping.
- **Done flag (unmapped addresses):** is due on the second edge after the write. The bench checks it at exactly that falling edge.
- **Busy writes:** a window write is driven while the responder is deliberately slow. The bench then confirms that both the result of the pending access and the count of internal accesses are unchanged.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_SKIP = 2'd2
  } seq_state_e;

  localparam int unsigned RNW_BIT = 14;
  localparam int unsigned DONE_BIT = 15;
endpackage

// File: rtl/regwin_remap.sv
module regwin_remap #(
  parameter int unsigned WIN_AW  = 6,
  parameter int unsigned IADDR_W = 8
) (
  input  logic [WIN_AW-1:0]  win_addr_i,
  output logic               valid_o,
  output logic [IADDR_W-1:0] ofs_o
);
  localparam int unsigned CW = (WIN_AW > IADDR_W) ? WIN_AW : IADDR_W;
  typedef logic [CW-1:0] cw_t;

  cw_t a;
  cw_t r;

  assign a = cw_t'(win_addr_i);

  always_comb begin
    valid_o = 1'b1;
    r       = a;
    if (a <= cw_t'(8'h05))      r = a;
    else if (a == cw_t'(8'h06)) r = cw_t'(8'h0A);
    else if (a <= cw_t'(8'h0A)) r = a - cw_t'(1);
    else if (a <= cw_t'(8'h0E)) r = a;
    else if (a == cw_t'(8'h0F)) r = cw_t'(8'h60);
    else if (a == cw_t'(8'h10)) r = a;
    else if (a <= cw_t'(8'h13)) r = a + cw_t'(1);   // skip 0x11
    else if (a <= cw_t'(8'h1B)) r = a + cw_t'(2);   // skip 0x15
    else begin
      valid_o = 1'b0;
      r       = '0;
    end
  end

  assign ofs_o = IADDR_W'(r);
endmodule

// File: rtl/regwin_seq.sv
module regwin_seq
  import regwin_pkg::*;
#(
  parameter int unsigned WIN_AW  = 6,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned IADDR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_req_i,
  input  logic               rnw_i,
  input  logic [DATA_W-1:0]  wbyte_i,
  input  logic               map_valid_i,
  input  logic [IADDR_W-1:0] map_ofs_i,
  input  logic               ack_i,
  input  logic [DATA_W-1:0]  rbyte_i,
  output logic               done_o,
  output logic [DATA_W-1:0]  data_o,
  output logic               req_o,
  output logic               we_o,
  output logic [IADDR_W-1:0] addr_o
);
  seq_state_e         state_q;
  logic               rnw_q;
  logic               done_q;
  logic [DATA_W-1:0]  data_q;
  logic [IADDR_W-1:0] ofs_q;
  logic               start;

  assign start = start_req_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rnw_q   <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      ofs_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            rnw_q   <= rnw_i;
            data_q  <= wbyte_i;
            ofs_q   <= map_ofs_i;
            done_q  <= 1'b0;
            state_q <= map_valid_i ? ST_BUS : ST_SKIP;
          end
        end
        ST_BUS: begin
          if (ack_i) begin
            done_q  <= 1'b1;
            if (rnw_q) data_q <= rbyte_i;
            state_q <= ST_IDLE;
          end
        end
        ST_SKIP: begin
          // unmapped address: no bus cycle, complete immediately
          done_q  <= 1'b1;
          if (rnw_q) data_q <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
  assign req_o  = (state_q == ST_BUS);
  assign we_o   = !rnw_q;
  assign addr_o = ofs_q;
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int unsigned WIN_AW  = 6,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned IADDR_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         win_we_i,
  input  logic [DATA_W+WIN_AW+1:0]     win_wdata_i,
  output logic [DATA_W+WIN_AW+1:0]     win_rdata_o,
  output logic                         ibus_req_o,
  output logic                         ibus_we_o,
  output logic [IADDR_W-1:0]           ibus_addr_o,
  output logic [DATA_W-1:0]            ibus_wdata_o,
  input  logic                         ibus_ack_i,
  input  logic [DATA_W-1:0]            ibus_rdata_i
);
  localparam int unsigned WIN_W = DATA_W + WIN_AW + 2;
  localparam int unsigned PAD_W = WIN_W - 1 - DATA_W;

  logic [WIN_AW-1:0]  win_addr;
  logic               map_valid;
  logic [IADDR_W-1:0] map_ofs;
  logic               done;
  logic [DATA_W-1:0]  data;
  logic               unused_done_wbit;

  assign win_addr         = win_wdata_i[DATA_W +: WIN_AW];
  assign unused_done_wbit = win_wdata_i[WIN_W-1];

  regwin_remap #(
    .WIN_AW (WIN_AW),
    .IADDR_W(IADDR_W)
  ) u_remap (
    .win_addr_i(win_addr),
    .valid_o   (map_valid),
    .ofs_o     (map_ofs)
  );

  regwin_seq #(
    .WIN_AW (WIN_AW),
    .DATA_W (DATA_W),
    .IADDR_W(IADDR_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_req_i(win_we_i),
    .rnw_i      (win_wdata_i[WIN_W-2]),
    .wbyte_i    (win_wdata_i[DATA_W-1:0]),
    .map_valid_i(map_valid),
    .map_ofs_i  (map_ofs),
    .ack_i      (ibus_ack_i),
    .rbyte_i    (ibus_rdata_i),
    .done_o     (done),
    .data_o     (data),
    .req_o      (ibus_req_o),
    .we_o       (ibus_we_o),
    .addr_o     (ibus_addr_o)
  );

  assign ibus_wdata_o = data;
  assign win_rdata_o  = {done, {PAD_W{1'b0}}, data};
endmodule

// File: rtl/regwin_bridge_chk.sv
module regwin_bridge_chk #(
  parameter int unsigned WIN_W   = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned IADDR_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               win_we_i,
  input logic [WIN_W-1:0]   win_rdata_o,
  input logic               ibus_req_o,
  input logic               ibus_we_o,
  input logic [IADDR_W-1:0] ibus_addr_o,
  input logic [DATA_W-1:0]  ibus_wdata_o,
  input logic               ibus_ack_i,
  input logic [DATA_W-1:0]  ibus_rdata_i
);
  logic done;
  logic legal_ofs;

  assign done = win_rdata_o[WIN_W-1];
  assign legal_ofs = (ibus_addr_o <= IADDR_W'(8'h1D)) && (ibus_addr_o != IADDR_W'(8'h11))
                     && (ibus_addr_o != IADDR_W'(8'h15)) || (ibus_addr_o == IADDR_W'(8'h60));

  AST_READBACK_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_rdata_o[WIN_W-2:DATA_W] == '0); // R1

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibus_req_o && !ibus_ack_i |=> ibus_req_o && $stable(ibus_addr_o)
      && $stable(ibus_we_o) && $stable(ibus_wdata_o)); // R2

  AST_START_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ibus_req_o) |-> !done); // R3

  AST_ACK_SETS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibus_req_o && ibus_ack_i |=> done && !ibus_req_o); // R3

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && !win_we_i |=> done); // R3

  AST_READ_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibus_req_o && ibus_ack_i && !ibus_we_o
      |=> win_rdata_o[DATA_W-1:0] == $past(ibus_rdata_i)); // R4

  AST_WRITE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibus_req_o && ibus_ack_i && ibus_we_o
      |=> win_rdata_o[DATA_W-1:0] == $past(ibus_wdata_o)); // R4

  AST_LEGAL_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibus_req_o |-> legal_ofs); // R7

  AST_BUSY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibus_req_o && !ibus_ack_i && win_we_i |=> $stable(ibus_addr_o)
      && $stable(ibus_wdata_o)); // R8
endmodule

bind regwin_bridge regwin_bridge_chk #(
  .WIN_W  (DATA_W + WIN_AW + 2),
  .DATA_W (DATA_W),
  .IADDR_W(IADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .win_we_i    (win_we_i),
  .win_rdata_o (win_rdata_o),
  .ibus_req_o  (ibus_req_o),
  .ibus_we_o   (ibus_we_o),
  .ibus_addr_o (ibus_addr_o),
  .ibus_wdata_o(ibus_wdata_o),
  .ibus_ack_i  (ibus_ack_i),
  .ibus_rdata_i(ibus_rdata_i)
);

// File: tb/sim_regwin_bridge.sv
module sim_regwin_bridge;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_we = 1'b0;
  logic [15:0] win_wdata = '0;
  logic [15:0] win_rdata;
  logic        req, we_b, ack;
  logic [7:0]  addr_b, wdata_b, rdata_b;

  int checks = 0;
  int fails = 0;
  int lat = 0;
  int acc_cnt = 0;
  int rsp_cnt = 0;
  logic [7:0] last_ofs;
  logic       last_we;
  logic [7:0] mem [256];
  logic [7:0] shadow [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  regwin_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .win_we_i(win_we), .win_wdata_i(win_wdata),
    .win_rdata_o(win_rdata), .ibus_req_o(req), .ibus_we_o(we_b),
    .ibus_addr_o(addr_b), .ibus_wdata_o(wdata_b), .ibus_ack_i(ack),
    .ibus_rdata_i(rdata_b)
  );

  // variable-latency responder
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; rdata_b <= '0; rsp_cnt <= 0; acc_cnt <= 0;
      last_ofs <= '0; last_we <= 1'b0;
    end else if (req && !ack) begin
      if (rsp_cnt >= lat) begin
        ack <= 1'b1;
        rdata_b <= mem[addr_b];
        if (we_b) mem[addr_b] <= wdata_b;
        last_ofs <= addr_b; last_we <= we_b;
        acc_cnt <= acc_cnt + 1;
        rsp_cnt <= 0;
      end else rsp_cnt <= rsp_cnt + 1;
    end else ack <= 1'b0;
  end

  function automatic logic [8:0] exp_map(input logic [5:0] a);
    case (a)
      6'h00: return 9'h100; 6'h01: return 9'h101; 6'h02: return 9'h102; 6'h03: return 9'h103;
      6'h04: return 9'h104; 6'h05: return 9'h105; 6'h06: return 9'h10A; 6'h07: return 9'h106;
      6'h08: return 9'h107; 6'h09: return 9'h108; 6'h0A: return 9'h109; 6'h0B: return 9'h10B;
      6'h0C: return 9'h10C; 6'h0D: return 9'h10D; 6'h0E: return 9'h10E; 6'h0F: return 9'h160;
      6'h10: return 9'h110; 6'h11: return 9'h112; 6'h12: return 9'h113; 6'h13: return 9'h114;
      6'h14: return 9'h116; 6'h15: return 9'h117; 6'h16: return 9'h118; 6'h17: return 9'h119;
      6'h18: return 9'h11A; 6'h19: return 9'h11B; 6'h1A: return 9'h11C; 6'h1B: return 9'h11D;
      default: return 9'h000; // bit 8 = mapped
    endcase
  endfunction

  function automatic string map_req(input logic [5:0] a);
    if (a > 6'h1B) return "R9";
    if (a == 6'h06 || (a >= 6'h07 && a <= 6'h0A) || a == 6'h0F) return "R6";
    if (a >= 6'h11) return "R7";
    return "R5";
  endfunction

  task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic write_win(input logic [5:0] a, input logic rnw, input logic [7:0] d);
    @(negedge clk);
    win_we = 1'b1;
    win_wdata = {1'b0, rnw, a, d};
    @(negedge clk);
    win_we = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (win_rdata[15]) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic access(input logic [5:0] a, input logic rnw, input logic [7:0] d);
    logic [8:0] m;
    int cnt0;
    bit ok;
    logic [7:0] exp_d;
    m = exp_map(a);
    cnt0 = acc_cnt;
    write_win(a, rnw, d);
    check("R3", {15'd0, win_rdata[15]}, 16'd0);
    if (!m[8]) begin
      check("R9", {15'd0, req}, 16'd0);
      @(negedge clk);
      check("R9", {15'd0, win_rdata[15]}, 16'd1);
      exp_d = rnw ? 8'h00 : d;
      check("R9", win_rdata, {8'h80, exp_d});
      check("R9", 16'(acc_cnt - cnt0), 16'd0);
      return;
    end
    check("R2", {15'd0, req}, 16'd1);
    wait_done(ok);
    check("R3", {15'd0, ok}, 16'd1);
    exp_d = rnw ? shadow[m[7:0]] : d;
    if (!rnw) shadow[m[7:0]] = d;
    check("R4", win_rdata, {8'h80, exp_d});
    check("R1", {8'd0, win_rdata[14:8]}, 16'd0);
    check(map_req(a), {8'd0, last_ofs}, {8'd0, m[7:0]});
    check("R2", {15'd0, last_we}, {15'd0, !rnw});
    check("R2", 16'(acc_cnt - cnt0), 16'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit ok;
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      shadow[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    check("R1", win_rdata, 16'h0000);
    check("R1", {15'd0, req}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: each mapping group and the boundaries
    lat = 0;
    access(6'h00, 1'b1, 8'h00);
    access(6'h05, 1'b1, 8'h00);
    access(6'h06, 1'b1, 8'h00);
    access(6'h07, 1'b0, 8'hC3);
    access(6'h07, 1'b1, 8'h00);
    access(6'h0A, 1'b1, 8'h00);
    lat = 3;
    access(6'h0B, 1'b0, 8'h11);
    access(6'h0F, 1'b1, 8'h00);
    access(6'h10, 1'b1, 8'h00);
    access(6'h11, 1'b1, 8'h00);
    access(6'h13, 1'b0, 8'h77);
    access(6'h14, 1'b1, 8'h00);
    access(6'h1B, 1'b1, 8'h00);
    access(6'h1C, 1'b1, 8'hAB);
    access(6'h3F, 1'b0, 8'h99);

    // R8: write while pending is dropped
    lat = 8;
    begin
      int cnt0;
      cnt0 = acc_cnt;
      write_win(6'h06, 1'b1, 8'h00);
      repeat (2) @(negedge clk);
      write_win(6'h01, 1'b0, 8'hEE);
      wait_done(ok);
      check("R8", {15'd0, ok}, 16'd1);
      check("R8", win_rdata, {8'h80, shadow[8'h0A]});
      check("R8", {8'd0, last_ofs}, 16'h000A);
      repeat (2) @(negedge clk);
      check("R8", 16'(acc_cnt - cnt0), 16'd1);
    end
    lat = 0;
    access(6'h01, 1'b1, 8'h00);

    // constrained random
    for (int n = 0; n < 120; n++) begin
      logic [5:0] a;
      a = ($urandom % 8 == 0) ? 6'($urandom % 64) : 6'($urandom % 28);
      lat = int'($urandom % 6);
      access(a, 1'($urandom % 2), 8'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule